// File: doc/BRIEF.md
# Tag-Renaming Multiply Scheduler

This block is a small dynamic scheduler for multiply instructions. Instructions arrive in program order on an issue port, each naming a destination register and two sources. A source is either an immediate or an architectural register. Every instruction goes to one of three multi-cycle multiply units, known as A, B and C. A register that still waits for a result is handed to the unit as the producer's tag rather than as a value. A status table records, for each register, which unit will write it next. When a unit finishes, its result is broadcast on a shared result bus. Units that are waiting for that tag pick the value up, and a register takes the value only if its tag still names the broadcasting unit.

The surrounding pipeline uses a register read port to see architectural values and pending state. It uses a write port to load registers directly. Because writers are renamed to unit tags, instructions can complete out of order. An older, slower result cannot overwrite a register that a younger instruction has already claimed.

Top module: `ooo_issue_unit`

## Requirements
- R1: After reset every register reads 0 and is not pending, `iss_ready` is 1 and `cdb_valid` is 0.
- R2: An issue is accepted at a clock edge where `iss_valid` and `iss_ready` are both 1. It goes to the first idle unit in the order A, B, C, whose bus tags are 1, 2 and 3. When no unit is idle, `iss_ready` is 0 and the request is ignored.
- R3: Once an issue is accepted, the destination register reads as pending (`rd_busy` = 1) until its result lands or the write port loads it.
- R4: A register source whose writer is still pending is captured as that writer's tag. The waiting unit takes the value from the bus when that tag is broadcast, and then starts its multiply.
- R5: If both operands are known at issue, the unit drives its result on the bus during the LAT-th cycle after the issue edge (LAT defaults to 4). The result is the low 16 bits of the product.
- R6: A bus result is written to a register only if the register's tag equals the broadcast tag, and that tag is then cleared. A stale result from an older writer leaves the register unchanged.
- R7: When several units have results in the same cycle, the lowest tag is granted the bus. The others keep their results and broadcast in later cycles, one per cycle, in tag order.
- R8: A source whose producer is broadcasting in the cycle of the issue takes its value straight from the bus.
- R9: The write port loads a value and clears the pending state. An in-flight result aimed at that register is then dropped.
- R10: After all work has drained, every register holds the value that executing the issued instructions one at a time in order would give.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | At least one unit is idle |
| iss_dst | input | 3 | Destination register |
| iss_a_is_reg | input | 1 | Source A is a register (1) or immediate (0) |
| iss_a_reg | input | 3 | Source A register index |
| iss_a_imm | input | 16 | Source A immediate |
| iss_b_is_reg | input | 1 | Source B is a register (1) or immediate (0) |
| iss_b_reg | input | 3 | Source B register index |
| iss_b_imm | input | 16 | Source B immediate |
| wr_en | input | 1 | Direct register write |
| wr_addr | input | 3 | Write register index |
| wr_data | input | 16 | Write value |
| rd_addr | input | 3 | Read register index |
| rd_data | output | 16 | Register value |
| rd_busy | output | 1 | Register awaits a unit result |
| cdb_valid | output | 1 | Result bus carries a result |
| cdb_tag | output | 2 | Tag of the broadcasting unit |
| cdb_data | output | 16 | Broadcast result |

## Verification
Two functions can land on the same cycle. Several units can finish together and compete for the bus, and an instruction can be issued while the producer of one of its sources is broadcasting. The first case is provoked by parking two units on one producer's tag so that both wake on the same edge. The bench then expects tags 2 and 3 on the bus in consecutive cycles with their products. The second case is provoked by issuing a dependent instruction exactly in the producer's bus cycle; the check is that the dependent result drains to the squared value instead of stalling forever. A sweep of generated programs then compares every register against an in-order arithmetic model.

// File: rtl/ooo_pkg.sv
package ooo_pkg;
  localparam int NUM_UNITS = 3;
  localparam int TAG_W     = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_BUSY = 2'd2,
    ST_DONE = 2'd3
  } unit_state_e;
endpackage

// File: rtl/ooo_prio_pick.sv
module ooo_prio_pick #(
  parameter int N = 3
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic [N:0] taken;
  assign taken[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_pick
    assign gnt[i]     = req[i] & ~taken[i];
    assign taken[i+1] = taken[i] | req[i];
  end
endmodule

// File: rtl/ooo_mul_station.sv
module ooo_mul_station
  import ooo_pkg::*;
#(
  parameter int DW  = 16,
  parameter int TW  = 2,
  parameter int LAT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc,
  input  logic          a_rdy,
  input  logic [TW-1:0] a_tag,
  input  logic [DW-1:0] a_val,
  input  logic          b_rdy,
  input  logic [TW-1:0] b_tag,
  input  logic [DW-1:0] b_val,
  input  logic          bus_vld,
  input  logic [TW-1:0] bus_tag,
  input  logic [DW-1:0] bus_data,
  input  logic          grant,
  output logic          idle,
  output logic          req,
  output logic [DW-1:0] result
);
  localparam int CW = (LAT < 2) ? 1 : $clog2(LAT);

  unit_state_e   st_q, st_d;
  logic [DW-1:0] opa_q, opa_d, opb_q, opb_d;
  logic          aok_q, aok_d, bok_q, bok_d;
  logic [TW-1:0] taga_q, taga_d, tagb_q, tagb_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d   = st_q;
    opa_d  = opa_q;
    opb_d  = opb_q;
    aok_d  = aok_q;
    bok_d  = bok_q;
    taga_d = taga_q;
    tagb_d = tagb_q;
    cnt_d  = cnt_q;
    unique case (st_q)
      ST_IDLE: if (alloc) begin
        opa_d  = a_val;
        opb_d  = b_val;
        aok_d  = a_rdy;
        bok_d  = b_rdy;
        taga_d = a_tag;
        tagb_d = b_tag;
        cnt_d  = CW'(LAT - 1);
        st_d   = (a_rdy && b_rdy) ? ST_BUSY : ST_WAIT;
      end
      ST_WAIT: begin
        if (!aok_q && bus_vld && bus_tag == taga_q) begin
          opa_d = bus_data;
          aok_d = 1'b1;
        end
        if (!bok_q && bus_vld && bus_tag == tagb_q) begin
          opb_d = bus_data;
          bok_d = 1'b1;
        end
        if (aok_d && bok_d) st_d = ST_BUSY;
      end
      ST_BUSY: begin
        if (cnt_q == '0) st_d = grant ? ST_IDLE : ST_DONE;
        else             cnt_d = cnt_q - 1'b1;
      end
      ST_DONE: if (grant) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      opa_q  <= '0;
      opb_q  <= '0;
      aok_q  <= 1'b0;
      bok_q  <= 1'b0;
      taga_q <= '0;
      tagb_q <= '0;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_d;
      opa_q  <= opa_d;
      opb_q  <= opb_d;
      aok_q  <= aok_d;
      bok_q  <= bok_d;
      taga_q <= taga_d;
      tagb_q <= tagb_d;
      cnt_q  <= cnt_d;
    end
  end

  assign idle   = (st_q == ST_IDLE);
  assign req    = (st_q == ST_DONE) || (st_q == ST_BUSY && cnt_q == '0);
  assign result = opa_q * opb_q;
endmodule

// File: rtl/ooo_reg_status.sv
module ooo_reg_status #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  parameter int TW   = 2,
  parameter int AW   = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_en,
  input  logic [AW-1:0]    iss_dst,
  input  logic [TW-1:0]    iss_tag,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             bus_vld,
  input  logic [TW-1:0]    bus_tag,
  input  logic [DW-1:0]    bus_data,
  input  logic [AW-1:0]    ra_addr,
  output logic [DW-1:0]    ra_val,
  output logic [TW-1:0]    ra_tag,
  input  logic [AW-1:0]    rb_addr,
  output logic [DW-1:0]    rb_val,
  output logic [TW-1:0]    rb_tag,
  input  logic [AW-1:0]    rx_addr,
  output logic [DW-1:0]    rx_val,
  output logic [TW-1:0]    rx_tag,
  output logic [NREG*TW-1:0] tag_flat
);
  logic [DW-1:0] val_q [NREG];
  logic [TW-1:0] tag_q [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic          hit_wr, hit_iss, hit_bus, val_en, tag_en;
    logic [DW-1:0] val_d;
    logic [TW-1:0] tag_d;

    assign hit_wr  = wr_en && wr_addr == AW'(r);
    assign hit_iss = iss_en && iss_dst == AW'(r);
    assign hit_bus = bus_vld && tag_q[r] == bus_tag;

    always_comb begin
      val_en = hit_wr || hit_bus;
      val_d  = hit_wr ? wr_data : bus_data;
      tag_en = hit_iss || hit_wr || hit_bus;
      tag_d  = hit_iss ? iss_tag : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q[r] <= '0;
        tag_q[r] <= '0;
      end else begin
        if (val_en) val_q[r] <= val_d;
        if (tag_en) tag_q[r] <= tag_d;
      end
    end

    assign tag_flat[r*TW +: TW] = tag_q[r];
  end

  assign ra_val = val_q[ra_addr];
  assign ra_tag = tag_q[ra_addr];
  assign rb_val = val_q[rb_addr];
  assign rb_tag = tag_q[rb_addr];
  assign rx_val = val_q[rx_addr];
  assign rx_tag = tag_q[rx_addr];
endmodule

// File: rtl/ooo_issue_unit.sv
module ooo_issue_unit
  import ooo_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 8,
  parameter int LAT  = 4,
  parameter int AW   = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  output logic             iss_ready,
  input  logic [AW-1:0]    iss_dst,
  input  logic             iss_a_is_reg,
  input  logic [AW-1:0]    iss_a_reg,
  input  logic [DW-1:0]    iss_a_imm,
  input  logic             iss_b_is_reg,
  input  logic [AW-1:0]    iss_b_reg,
  input  logic [DW-1:0]    iss_b_imm,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  output logic             rd_busy,
  output logic             cdb_valid,
  output logic [TAG_W-1:0] cdb_tag,
  output logic [DW-1:0]    cdb_data
);
  localparam int NU = NUM_UNITS;
  localparam int TW = TAG_W;

  logic [NU-1:0]      unit_idle, unit_req, unit_gnt, pick, alloc;
  logic [DW-1:0]      unit_res [NU];
  logic [DW-1:0]      ra_val, rb_val;
  logic [TW-1:0]      ra_tag, rb_tag, rx_tag, iss_tag;
  logic [NREG*TW-1:0] tag_flat;
  logic               a_rdy, b_rdy, iss_fire;
  logic [TW-1:0]      a_tag, b_tag;
  logic [DW-1:0]      a_val, b_val;

  ooo_prio_pick #(.N(NU)) u_issue_pick (.req(unit_idle), .gnt(pick));
  ooo_prio_pick #(.N(NU)) u_bus_arb    (.req(unit_req),  .gnt(unit_gnt));

  assign iss_ready = |unit_idle;
  assign iss_fire  = iss_valid && iss_ready;
  assign alloc     = pick & {NU{iss_valid}};

  always_comb begin
    iss_tag  = '0;
    cdb_tag  = '0;
    cdb_data = '0;
    for (int i = 0; i < NU; i++) begin
      if (pick[i])     iss_tag  = iss_tag  | TW'(i + 1);
      if (unit_gnt[i]) cdb_tag  = cdb_tag  | TW'(i + 1);
      if (unit_gnt[i]) cdb_data = cdb_data | unit_res[i];
    end
  end
  assign cdb_valid = |unit_gnt;

  // Operand resolution with same-cycle bus forwarding
  always_comb begin
    a_rdy = 1'b1;  a_tag = '0;  a_val = iss_a_imm;
    if (iss_a_is_reg) begin
      a_val = ra_val;
      if (ra_tag != '0) begin
        if (cdb_valid && cdb_tag == ra_tag) a_val = cdb_data;
        else begin a_rdy = 1'b0; a_tag = ra_tag; end
      end
    end
    b_rdy = 1'b1;  b_tag = '0;  b_val = iss_b_imm;
    if (iss_b_is_reg) begin
      b_val = rb_val;
      if (rb_tag != '0) begin
        if (cdb_valid && cdb_tag == rb_tag) b_val = cdb_data;
        else begin b_rdy = 1'b0; b_tag = rb_tag; end
      end
    end
  end

  for (genvar u = 0; u < NU; u++) begin : g_unit
    ooo_mul_station #(.DW(DW), .TW(TW), .LAT(LAT)) u_station (
      .clk(clk), .rst_n(rst_n), .alloc(alloc[u]),
      .a_rdy(a_rdy), .a_tag(a_tag), .a_val(a_val),
      .b_rdy(b_rdy), .b_tag(b_tag), .b_val(b_val),
      .bus_vld(cdb_valid), .bus_tag(cdb_tag), .bus_data(cdb_data),
      .grant(unit_gnt[u]), .idle(unit_idle[u]), .req(unit_req[u]),
      .result(unit_res[u])
    );
  end

  ooo_reg_status #(.DW(DW), .NREG(NREG), .TW(TW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .iss_en(iss_fire), .iss_dst(iss_dst), .iss_tag(iss_tag),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .bus_vld(cdb_valid), .bus_tag(cdb_tag), .bus_data(cdb_data),
    .ra_addr(iss_a_reg), .ra_val(ra_val), .ra_tag(ra_tag),
    .rb_addr(iss_b_reg), .rb_val(rb_val), .rb_tag(rb_tag),
    .rx_addr(rd_addr), .rx_val(rd_data), .rx_tag(rx_tag),
    .tag_flat(tag_flat)
  );
  assign rd_busy = (rx_tag != '0);
endmodule

// File: rtl/ooo_issue_checker.sv
module ooo_issue_checker #(
  parameter int NU   = 3,
  parameter int NREG = 8,
  parameter int TW   = 2,
  parameter int AW   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NU-1:0]    unit_req,
  input logic [NU-1:0]    unit_gnt,
  input logic [NU-1:0]    unit_idle,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic [AW-1:0]    iss_dst,
  input logic [NREG*TW-1:0] tag_flat
);
  AST_BUS_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(unit_gnt)); // R7

  AST_DST_TAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready) |=> (tag_flat[$past(iss_dst)*TW +: TW] != '0)); // R3

  for (genvar u = 0; u < NU; u++) begin : g_u
    AST_LOSER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (unit_req[u] && !unit_gnt[u]) |=> unit_req[u]); // R7
    AST_IDLE_AFTER_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
      unit_gnt[u] |=> unit_idle[u]); // R6
  end

  for (genvar r = 0; r < NREG; r++) begin : g_r
    AST_TAG_NAMES_LIVE_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
      (tag_flat[r*TW +: TW] != '0) |-> !unit_idle[tag_flat[r*TW +: TW] - 1'b1]); // R6
  end
endmodule

bind ooo_issue_unit ooo_issue_checker #(
  .NU(ooo_pkg::NUM_UNITS), .NREG(NREG), .TW(ooo_pkg::TAG_W), .AW(AW)
) u_checker (
  .clk(clk), .rst_n(rst_n), .unit_req(unit_req), .unit_gnt(unit_gnt),
  .unit_idle(unit_idle), .iss_valid(iss_valid), .iss_ready(iss_ready),
  .iss_dst(iss_dst), .tag_flat(tag_flat)
);

// File: tb/ooo_issue_unit_bench.sv
module ooo_issue_unit_bench;
  localparam int DW = 16, NREG = 8, LAT = 4, AW = 3;

  logic clk, rst_n;
  logic iss_valid, iss_ready, iss_a_is_reg, iss_b_is_reg;
  logic [AW-1:0] iss_dst, iss_a_reg, iss_b_reg, wr_addr, rd_addr;
  logic [DW-1:0] iss_a_imm, iss_b_imm, wr_data, rd_data, cdb_data;
  logic wr_en, rd_busy, cdb_valid;
  logic [1:0] cdb_tag;

  int checks = 0, errors = 0, cyc = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [DW-1:0] model [NREG];

  ooo_issue_unit #(.DW(DW), .NREG(NREG), .LAT(LAT)) u_ooo_issue_unit (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_dst(iss_dst), .iss_a_is_reg(iss_a_is_reg), .iss_a_reg(iss_a_reg),
    .iss_a_imm(iss_a_imm), .iss_b_is_reg(iss_b_is_reg), .iss_b_reg(iss_b_reg),
    .iss_b_imm(iss_b_imm), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_busy(rd_busy),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rnd(output int v, input int m);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    v = int'(lfsr) % m;
  endtask

  // called at a negedge, returns at the negedge after the accepting edge
  task automatic do_issue(input int d, input bit asel, input int av,
                          input bit bsel, input int bv);
    iss_valid = 1'b1;  iss_dst = AW'(d);
    iss_a_is_reg = asel; iss_a_reg = AW'(av); iss_a_imm = DW'(av);
    iss_b_is_reg = bsel; iss_b_reg = AW'(bv); iss_b_imm = DW'(bv);
    while (!iss_ready) @(negedge clk);
    @(negedge clk);
    iss_valid = 1'b0;
  endtask

  task automatic do_write(input int a, input int v);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(v);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v, output int b);
    rd_addr = AW'(a);
    #0.5;
    v = int'(rd_data);
    b = int'(rd_busy);
  endtask

  initial begin
    int v, b;
    rst_n = 1'b0; iss_valid = 1'b0; wr_en = 1'b0; rd_addr = '0;
    iss_dst = '0; iss_a_is_reg = 1'b0; iss_b_is_reg = 1'b0;
    iss_a_reg = '0; iss_b_reg = '0; iss_a_imm = '0; iss_b_imm = '0;
    wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 iss_ready", int'(iss_ready), 1);
    chk("R1 cdb_valid", int'(cdb_valid), 0);
    for (int r = 0; r < NREG; r++) begin
      rd(r, v, b);
      chk("R1 reg value", v, 0);
      chk("R1 reg busy", b, 0);
    end

    // Renaming scenario: r1=2*3, r2=r1*4, r2=5*6
    do_issue(1, 0, 2, 0, 3);
    rd(1, v, b); chk("R3 r1 pending", b, 1);
    do_issue(2, 1, 1, 0, 4);
    do_issue(2, 0, 5, 0, 6);
    @(negedge clk);
    chk("R5 bus valid at LAT", int'(cdb_valid), 1);
    chk("R2 first unit tag A", int'(cdb_tag), 1);
    chk("R5 product", int'(cdb_data), 6);
    repeat (2) @(negedge clk);
    chk("R2 third unit tag C", int'(cdb_tag), 3);
    chk("R5 product C", int'(cdb_data), 30);
    repeat (2) @(negedge clk);
    chk("R4 waiting unit B tag", int'(cdb_tag), 2);
    chk("R4 captured operand product", int'(cdb_data), 24);
    @(negedge clk);
    rd(2, v, b); chk("R6 stale result dropped", v, 30); chk("R6 tag cleared", b, 0);
    rd(1, v, b); chk("R6 r1 written", v, 6);
    repeat (4) @(negedge clk);

    // Simultaneous completion and stall: r1=2*3, r2=r1*4, r3=r1*5
    do_issue(1, 0, 2, 0, 3);
    do_issue(2, 1, 1, 0, 4);
    do_issue(3, 1, 1, 0, 5);
    chk("R2 stall ready low", int'(iss_ready), 0);
    iss_valid = 1'b1; iss_dst = 3'd6; iss_a_is_reg = 1'b0; iss_b_is_reg = 1'b0;
    iss_a_imm = 16'd9; iss_b_imm = 16'd9;
    @(negedge clk);
    iss_valid = 1'b0;
    rd(6, v, b); chk("R2 stalled issue ignored", b, 0);
    chk("R4 producer broadcast tag", int'(cdb_tag), 1);
    repeat (4) @(negedge clk);
    chk("R7 winner valid", int'(cdb_valid), 1);
    chk("R7 lowest tag wins", int'(cdb_tag), 2);
    chk("R7 winner data", int'(cdb_data), 24);
    @(negedge clk);
    chk("R7 loser next cycle", int'(cdb_tag), 3);
    chk("R7 loser data", int'(cdb_data), 30);
    @(negedge clk);
    chk("R7 bus idle after", int'(cdb_valid), 0);
    rd(3, v, b); chk("R7 r3 result", v, 30);
    rd(6, v, b); chk("R2 ignored issue left r6", v, 0);
    repeat (4) @(negedge clk);

    // Same-cycle forwarding: r1=7*3, r4=r1*r1 issued in r1's bus cycle
    do_issue(1, 0, 7, 0, 3);
    repeat (3) @(negedge clk);
    chk("R8 producer on bus", int'(cdb_valid), 1);
    do_issue(4, 1, 1, 1, 1);
    repeat (12) @(negedge clk);
    rd(4, v, b); chk("R8 forwarded result", v, 441); chk("R8 not pending", b, 0);

    // Write port overrides in-flight writer
    do_issue(5, 0, 3, 0, 7);
    do_write(5, 100);
    rd(5, v, b); chk("R9 write value", v, 100); chk("R9 pending cleared", b, 0);
    repeat (10) @(negedge clk);
    rd(5, v, b); chk("R9 late result dropped", v, 100);

    // Program sweep against in-order model
    for (int p = 0; p < 30; p++) begin
      for (int r = 0; r < NREG; r++) begin
        int x;
        rnd(x, 50);
        model[r] = DW'(x);
        do_write(r, x);
      end
      for (int k = 0; k < 12; k++) begin
        int d, as, av, bs, bv;
        logic [DW-1:0] oa, ob;
        rnd(d, NREG); rnd(as, 2); rnd(bs, 2);
        rnd(av, as != 0 ? NREG : 16); rnd(bv, bs != 0 ? NREG : 16);
        oa = (as != 0) ? model[av] : DW'(av);
        ob = (bs != 0) ? model[bv] : DW'(bv);
        model[d] = oa * ob;
        do_issue(d, as != 0, av, bs != 0, bv);
      end
      repeat (30) @(negedge clk);
      for (int r = 0; r < NREG; r++) begin
        rd(r, v, b);
        chk("R10 in-order result", v, int'(model[r]));
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule